// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block holds the small set of housekeeping registers that sit beside an I/O controller in a workstation: a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes with side effects, a 16-bit LED word, a 32-bit system-control word and a one-byte CPU-idle window. An upstream decoder turns bus addresses into one strobe per window. This block then performs single-cycle writes and combinational reads.

The auxiliary bytes drive the system-level controls. A write to the first auxiliary byte can fire a floppy terminal-count pulse. The second auxiliary byte holds a sticky power-fail flag that raises an interrupt when it is enabled, and it also carries the power-off command. The system-control word requests a full system reset. Writing the idle window halts the CPU until an external wake-up arrives.

The access port is a plain synchronous port, not a stream. Every access completes in the cycle its strobe is presented, so the port never applies back-pressure and has no valid/ready pair. Read data is valid in the same cycle as the strobe.

Top module: `aux_sysctl_regs`

## Requirements
- R1: While reset is low and after it is released, reads of configuration, modem control, aux1 and aux2 return 0, and all five outputs `pf_irq`, `fd_tc`, `pwr_off_req`, `sys_rst_req` and `cpu_halt` are low.
- R2: Reset leaves the diagnostic byte, the LED word and the system-control word unchanged.
- R3: `sel` bit positions are: configuration 0, diagnostic 1, modem 2, aux1 3, aux2 4, LED 5, system control 6, idle 7. For configuration, diagnostic and modem, a write stores `wdata[7:0]`, and a read returns that byte zero-extended to 32 bits whatever `off` is.
- R4: A write to aux1 with data bit 1 set makes `fd_tc` high for exactly the following cycle. Aux1 stores the written byte with bit 1 forced to 0. A write with bit 1 clear gives no pulse.
- R5: An aux2 write takes only data bits 0 and 1 and keeps the stored power-fail flag (bit 5). If data bit 1 is set, the result keeps only bit 0, which clears the flag. Bit 1 always reads back as 0.
- R6: When `pwr_failing` changes, the power-fail flag becomes 1 if the new level is high and configuration bit 3 is 1, and otherwise becomes 0. When the input does not change, the flag does not change on its own.
- R7: `pf_irq` is high exactly when the power-fail flag is 1 and configuration bit 3 is 1. It follows configuration writes in the next cycle.
- R8: An aux2 write that stores bit 0 = 1 makes `pwr_off_req` high for exactly the following cycle.
- R9: A system-control write at `off`=0 with data bit 0 set loads the word with 0x2 and makes `sys_rst_req` high for exactly the following cycle. A write with bit 0 clear, or a write at any other offset, changes nothing. Reads at nonzero offsets return 0.
- R10: The LED word stores `wdata[15:0]` only on writes at `off`=0. Reads at `off`=0 return it, and reads at other offsets return 0.
- R11: A write of any value to the idle window sets `cpu_halt` from the next cycle. It stays set until a cycle with `wake` high and no idle write. Reads of the idle window return 0.
- R12: At most one `sel` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 8 | One strobe per register window |
| we | input | 1 | 1 = write, 0 = read for the selected window |
| off | input | 2 | Offset inside the LED and system-control windows |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero-extended |
| pwr_failing | input | 1 | Power-failing indication from the supply |
| wake | input | 1 | Clears the CPU halt |
| pf_irq | output | 1 | Power-fail interrupt |
| fd_tc | output | 1 | Floppy terminal-count pulse |
| pwr_off_req | output | 1 | Power-off request pulse |
| sys_rst_req | output | 1 | System reset request pulse |
| cpu_halt | output | 1 | CPU idle halt level |

## Verification
A wrong flag in aux2 shows up at `pf_irq` and in the aux2 read value in the cycle after the write or input change that corrupted it. A wrong enable bit shows up only when a later power event or write depends on it. A stored terminal-count bit, or a pulse that lasts two cycles, is visible one cycle after the aux1 write. A reset that clears too much shows up in the first read of the diagnostic, LED or system-control window after reset. A halt that never clears shows up in the cycle after `wake`.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int BYTE_W     = 8;
  localparam int WIN_N      = 8;
  localparam int WIN_CFG    = 0;
  localparam int WIN_DIAG   = 1;
  localparam int WIN_MODEM  = 2;
  localparam int WIN_AUX1   = 3;
  localparam int WIN_AUX2   = 4;
  localparam int WIN_LED    = 5;
  localparam int WIN_SYS    = 6;
  localparam int WIN_IDLE   = 7;

  localparam int CFG_PFIE_BIT = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int SYS_RST_BIT  = 0;
  localparam int SYS_STAT_VAL = 2;

  localparam int EV_TC   = 0;
  localparam int EV_OFF  = 1;
  localparam int EV_RST  = 2;
  localparam int EV_N    = 3;
endpackage

// File: rtl/aux_event_pulse.sv
module aux_event_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= trig;
  end

  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse); // R4
endmodule

// File: rtl/aux_pwr_ctrl.sv
module aux_pwr_ctrl
  import aux_sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              aux2_wr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              pf_in,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] aux2_q,
  output logic              irq,
  output logic              off_trig
);
  logic              pf_prev;
  logic              pf_chg;
  logic [BYTE_W-1:0] aux2_nxt;

  assign pf_chg = pf_in != pf_prev;

  always_comb begin
    aux2_nxt = aux2_q;
    if (aux2_wr) begin
      aux2_nxt = '0;
      aux2_nxt[AUX2_OFF_BIT] = wbyte[AUX2_OFF_BIT];
      if (!wbyte[AUX2_CLR_BIT])
        aux2_nxt[AUX2_PF_BIT] = aux2_q[AUX2_PF_BIT];
    end
    if (pf_chg)
      aux2_nxt[AUX2_PF_BIT] = pf_in & cfg_q[CFG_PFIE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      aux2_q  <= '0;
      pf_prev <= 1'b0;
    end else begin
      pf_prev <= pf_in;
      aux2_q  <= aux2_nxt;
      if (cfg_wr) cfg_q <= wbyte;
    end
  end

  assign irq      = aux2_q[AUX2_PF_BIT] & cfg_q[CFG_PFIE_BIT];
  assign off_trig = aux2_wr & wbyte[AUX2_OFF_BIT];

  AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (aux2_wr && wbyte[AUX2_CLR_BIT] && !pf_chg) |=> !irq); // R5
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux2_wr && !pf_chg) |=> $stable(aux2_q[AUX2_PF_BIT])); // R6
  AST_NO_CLR_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    aux2_wr |=> !aux2_q[AUX2_CLR_BIT]); // R5
endmodule

// File: rtl/aux_halt_latch.sv
module aux_halt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wake,
  output logic halt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    halt <= 1'b0;
    else if (set)  halt <= 1'b1;
    else if (wake) halt <= 1'b0;
  end

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wake) |=> halt); // R11
  AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> halt); // R11
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int LED_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_N-1:0]  sel,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_failing,
  input  logic              wake,
  output logic              pf_irq,
  output logic              fd_tc,
  output logic              pwr_off_req,
  output logic              sys_rst_req,
  output logic              cpu_halt
);
  localparam logic [DATA_W-1:0] SYS_STAT = DATA_W'(SYS_STAT_VAL);

  logic [WIN_N-1:0]  wr_hit;
  logic [BYTE_W-1:0] wbyte;
  logic              off_zero;
  logic [BYTE_W-1:0] cfg_q, aux2_q, diag_q, modem_q, aux1_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sys_q;
  logic [EV_N-1:0]   ev_trig, ev_pulse;
  logic              off_trig;

  assign wr_hit   = sel & {WIN_N{we}};
  assign wbyte    = wdata[BYTE_W-1:0];
  assign off_zero = off == '0;

  aux_pwr_ctrl u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (wr_hit[WIN_CFG]),
    .aux2_wr  (wr_hit[WIN_AUX2]),
    .wbyte    (wbyte),
    .pf_in    (pwr_failing),
    .cfg_q    (cfg_q),
    .aux2_q   (aux2_q),
    .irq      (pf_irq),
    .off_trig (off_trig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modem_q <= '0;
      aux1_q  <= '0;
    end else begin
      if (wr_hit[WIN_MODEM]) modem_q <= wbyte;
      if (wr_hit[WIN_AUX1])
        aux1_q <= wbyte & ~(BYTE_W'(1) << AUX1_TC_BIT);
    end
  end

  // Retained across reset
  always_ff @(posedge clk) begin
    if (wr_hit[WIN_DIAG]) diag_q <= wbyte;
    if (wr_hit[WIN_LED] && off_zero) led_q <= wdata[LED_W-1:0];
    if (wr_hit[WIN_SYS] && off_zero && wdata[SYS_RST_BIT]) sys_q <= SYS_STAT;
  end

  assign ev_trig[EV_TC]  = wr_hit[WIN_AUX1] & wbyte[AUX1_TC_BIT];
  assign ev_trig[EV_OFF] = off_trig;
  assign ev_trig[EV_RST] = wr_hit[WIN_SYS] & off_zero & wdata[SYS_RST_BIT];

  for (genvar g = 0; g < EV_N; g++) begin : g_ev
    aux_event_pulse u_ev (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (ev_trig[g]),
      .pulse (ev_pulse[g])
    );
  end

  assign fd_tc       = ev_pulse[EV_TC];
  assign pwr_off_req = ev_pulse[EV_OFF];
  assign sys_rst_req = ev_pulse[EV_RST];

  aux_halt_latch u_halt (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wr_hit[WIN_IDLE]),
    .wake  (wake),
    .halt  (cpu_halt)
  );

  always_comb begin
    rdata = '0;
    if (sel[WIN_CFG])   rdata[BYTE_W-1:0] = cfg_q;
    if (sel[WIN_DIAG])  rdata[BYTE_W-1:0] = diag_q;
    if (sel[WIN_MODEM]) rdata[BYTE_W-1:0] = modem_q;
    if (sel[WIN_AUX1])  rdata[BYTE_W-1:0] = aux1_q;
    if (sel[WIN_AUX2])  rdata[BYTE_W-1:0] = aux2_q;
    if (sel[WIN_LED] && off_zero) rdata[LED_W-1:0] = led_q;
    if (sel[WIN_SYS] && off_zero) rdata = sys_q;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R12
  AST_SYS_RESET_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[WIN_SYS] && off_zero && wdata[SYS_RST_BIT]) |=>
      (sys_rst_req && sys_q == SYS_STAT)); // R9
  AST_PWROFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |-> $past(wr_hit[WIN_AUX2])); // R8
  AST_TC_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[WIN_AUX1] |=> !aux1_q[AUX1_TC_BIT]); // R4
endmodule

// File: tb/test_aux_sysctl_regs.sv
`timescale 1ns/1ps
module test_aux_sysctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sel = '0;
  logic        we = 1'b0;
  logic [1:0]  off = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwr_failing = 1'b0;
  logic        wake = 1'b0;
  logic        pf_irq, fd_tc, pwr_off_req, sys_rst_req, cpu_halt;

  always #2 clk = ~clk;

  aux_sysctl_regs i_aux_sysctl_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .off(off), .wdata(wdata),
    .rdata(rdata), .pwr_failing(pwr_failing), .wake(wake), .pf_irq(pf_irq),
    .fd_tc(fd_tc), .pwr_off_req(pwr_off_req), .sys_rst_req(sys_rst_req),
    .cpu_halt(cpu_halt)
  );

  localparam int S_RD = 0, S_IRQ = 1, S_TC = 2, S_OFF = 3, S_RST = 4, S_HALT = 5;
  localparam int W_CFG = 0, W_DIAG = 1, W_MODEM = 2, W_AUX1 = 3, W_AUX2 = 4,
                 W_LED = 5, W_SYS = 6, W_IDLE = 7;

  typedef struct {
    int          sig;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic push(int sig, logic [31:0] exp, string req);
    item_t it;
    it.sig = sig; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(int idx, logic [1:0] o, logic [31:0] d);
    sel = '0; sel[idx] = 1'b1; we = 1'b1; off = o; wdata = d;
    @(negedge clk);
    sel = '0; we = 1'b0; off = '0; wdata = '0;
  endtask

  task automatic rd(int idx, logic [1:0] o, logic [31:0] exp, string req);
    sel = '0; sel[idx] = 1'b1; we = 1'b0; off = o;
    push(S_RD, exp, req);
    @(negedge clk);
    sel = '0; off = '0;
  endtask

  // Monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sig)
          S_RD:    act = rdata;
          S_IRQ:   act = {31'b0, pf_irq};
          S_TC:    act = {31'b0, fd_tc};
          S_OFF:   act = {31'b0, pwr_off_req};
          S_RST:   act = {31'b0, sys_rst_req};
          default: act = {31'b0, cpu_halt};
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1: state during reset
    push(S_IRQ, 0, "R1"); push(S_TC, 0, "R1"); push(S_HALT, 0, "R1");
    rst_n = 1'b1;
    step();
    rd(W_CFG, 0, 0, "R1"); rd(W_MODEM, 0, 0, "R1");
    rd(W_AUX1, 0, 0, "R1"); rd(W_AUX2, 0, 0, "R1");
    push(S_OFF, 0, "R1"); push(S_RST, 0, "R1"); push(S_IRQ, 0, "R1");

    // R3: byte registers
    wr(W_CFG, 0, 32'hFFFF_FFA5);
    rd(W_CFG, 2'd3, 32'h0000_00A5, "R3");
    wr(W_DIAG, 0, 32'h1234_563C);
    rd(W_DIAG, 0, 32'h3C, "R3");
    wr(W_MODEM, 0, 32'h5A);
    rd(W_MODEM, 0, 32'h5A, "R3");

    // R4: terminal-count pulse
    wr(W_AUX1, 0, 32'hFF);
    push(S_TC, 1, "R4");
    step();
    push(S_TC, 0, "R4");
    rd(W_AUX1, 0, 32'hFD, "R4");
    wr(W_AUX1, 0, 32'h01);
    push(S_TC, 0, "R4");
    rd(W_AUX1, 0, 32'h01, "R4");

    // R10: LED word
    wr(W_LED, 0, 32'h1234_BEEF);
    rd(W_LED, 0, 32'hBEEF, "R10");
    wr(W_LED, 1, 32'h5555);
    rd(W_LED, 0, 32'hBEEF, "R10");
    rd(W_LED, 1, 32'h0, "R10");

    // R9: system control
    wr(W_SYS, 0, 32'h1);
    push(S_RST, 1, "R9");
    step();
    push(S_RST, 0, "R9");
    rd(W_SYS, 0, 32'h2, "R9");
    wr(W_SYS, 2, 32'hFFFF_FFFF);
    push(S_RST, 0, "R9");
    rd(W_SYS, 0, 32'h2, "R9");
    rd(W_SYS, 2, 32'h0, "R9");
    wr(W_SYS, 0, 32'hFE);
    push(S_RST, 0, "R9");
    rd(W_SYS, 0, 32'h2, "R9");

    // R6 / R7: power-fail flag and interrupt
    wr(W_CFG, 0, 32'h08);
    pwr_failing = 1'b1;
    step();
    push(S_IRQ, 1, "R7");
    rd(W_AUX2, 0, 32'h20, "R6");
    wr(W_CFG, 0, 32'h00);
    push(S_IRQ, 0, "R7");
    rd(W_AUX2, 0, 32'h20, "R6");
    wr(W_CFG, 0, 32'h08);
    push(S_IRQ, 1, "R7");

    // R5: aux2 write keeps flag, clear bit drops it
    wr(W_AUX2, 0, 32'hFC);
    push(S_IRQ, 1, "R5");
    rd(W_AUX2, 0, 32'h20, "R5");
    wr(W_AUX2, 0, 32'h02);
    push(S_IRQ, 0, "R5"); push(S_OFF, 0, "R5");
    rd(W_AUX2, 0, 32'h00, "R5");

    // R6: enable off blocks flag; low input clears it
    pwr_failing = 1'b0;
    wr(W_CFG, 0, 32'h00);
    pwr_failing = 1'b1;
    step();
    rd(W_AUX2, 0, 32'h00, "R6");
    push(S_IRQ, 0, "R6");
    pwr_failing = 1'b0;
    wr(W_CFG, 0, 32'h08);
    pwr_failing = 1'b1;
    step();
    rd(W_AUX2, 0, 32'h20, "R6");
    pwr_failing = 1'b0;
    step();
    rd(W_AUX2, 0, 32'h00, "R6");
    push(S_IRQ, 0, "R6");

    // R8: power-off request
    wr(W_AUX2, 0, 32'h01);
    push(S_OFF, 1, "R8");
    rd(W_AUX2, 0, 32'h01, "R8");
    push(S_OFF, 0, "R8");
    wr(W_AUX2, 0, 32'h03);
    push(S_OFF, 1, "R8");
    rd(W_AUX2, 0, 32'h01, "R8");

    // R11: idle halt
    wr(W_IDLE, 0, 32'h0);
    push(S_HALT, 1, "R11");
    step(); step();
    push(S_HALT, 1, "R11");
    rd(W_IDLE, 0, 32'h0, "R11");
    wake = 1'b1;
    step();
    wake = 1'b0;
    push(S_HALT, 0, "R11");
    step();

    // R2: retained registers across reset
    wr(W_CFG, 0, 32'h08);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    rd(W_DIAG, 0, 32'h3C, "R2");
    rd(W_LED, 0, 32'hBEEF, "R2");
    rd(W_SYS, 0, 32'h2, "R2");
    rd(W_CFG, 0, 32'h0, "R1");
    rd(W_AUX2, 0, 32'h0, "R1");

    step(); step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule